// File: doc/BRIEF.md
# Mod-250 Pulse-Width Modulator with Buffered Duty

This block produces one PWM output from a free-running period counter that steps from 0 to 249 on each count-enable tick and then returns to 0, so one period is 250 ticks. A host-visible duty value, in steps of 1/250, sets how many ticks of each period the output spends high. The output goes low when the counter equals the active duty value and goes high again at the start of the next period.

The duty value is held in two registers. The host writes a pending copy. That copy moves to the active copy at the 249-to-0 wrap, so a period that has already started is never cut short or stretched. While the output enable is low, the pin is held at 0 and a write takes effect at once. A read always returns the active duty value. Reset loads 0xFF into both copies, and any value of 250 or more gives a full-high output.

Top module: `pwm_mod250`

## Requirements
- R1: After synchronous reset, rd_data_o reads 0xFF, pwm_o is 0 and the period counter is at 0.
- R2: An active duty value of 0 keeps pwm_o at 0 for the whole period.
- R3: The period counter advances by one only in cycles with tick_i high, wraps from 249 to 0, and holds its value when tick_i is low. A period is therefore 250 ticks.
- R4: pwm_o in cycle t+1 is 1 exactly when oe_i is 1 and the counter value is below the active duty value in cycle t. Over one period, a duty value d gives min(d,250) high ticks, so 125 gives 50%.
- R5: While oe_i is 1, a written value stays pending. It becomes active only in a cycle with tick_i high and the counter at 249, and the active value does not change at any other time.
- R6: While oe_i is 0, a write makes the written value active in the next cycle.
- R7: rd_data_o always returns the active duty value, never a pending value that has not yet taken effect.
- R8: A write in the same cycle as the 249-to-0 wrap makes the newly written value the active one.
- R9: While oe_i is 0, pwm_o is 0 from the next cycle on, and the counter keeps running on tick_i.
- R10: An active duty value of 250 to 255 never matches the counter, so pwm_o stays 1 for the whole period while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable; the counter steps in each cycle where this is high |
| oe_i | input | 1 | Output enable; when low the pin is forced low and writes take effect at once |
| wr_en_i | input | 1 | Host write strobe for the duty value |
| wr_data_i | input | 8 | Duty value to write |
| rd_data_o | output | 8 | Active duty value |
| pwm_o | output | 1 | Registered PWM output |

## Verification
Every duty code from 0 to 255 is loaded through the immediate path and then run for one full enabled period. The count of high ticks separates the 0% case, the linear range and the saturated codes from 250 up. Writes placed mid-period, exactly on the wrap, and during ticks held low separate the deferred transfer from the immediate one and show whether the counter stalls correctly. A long disabled stretch followed by a re-enable shows that the pin stays low while the counter keeps its phase. A cycle-by-cycle model of the counter, both duty copies and the pin is compared with rd_data_o and pwm_o after every clock.

// File: rtl/pwm_mod250_pkg.sv
package pwm_mod250_pkg;
  localparam int unsigned DEF_DUTY_W = 8;
  localparam int unsigned DEF_PERIOD = 250;
  localparam int unsigned DEF_RESET_DUTY = 255;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int unsigned PERIOD = pwm_mod250_pkg::DEF_PERIOD,
  localparam int unsigned CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign wrap_o  = tick_i && at_last;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (at_last) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q)); // R3
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/pwm_duty_buffer.sv
module pwm_duty_buffer #(
  parameter int unsigned DUTY_W = pwm_mod250_pkg::DEF_DUTY_W,
  parameter int unsigned RESET_DUTY = pwm_mod250_pkg::DEF_RESET_DUTY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_i,
  input  logic              wrap_i,
  input  logic              wr_en_i,
  input  logic [DUTY_W-1:0] wr_data_i,
  output logic [DUTY_W-1:0] active_o
);
  localparam logic [DUTY_W-1:0] RST_VAL = DUTY_W'(RESET_DUTY);

  logic [DUTY_W-1:0] pend_q;
  logic [DUTY_W-1:0] active_q;
  logic [DUTY_W-1:0] pend_view;

  // A write in the wrap cycle wins over the older pending value.
  assign pend_view = wr_en_i ? wr_data_i : pend_q;
  assign active_o  = active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= RST_VAL;
    end else if (wr_en_i) begin
      pend_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= RST_VAL;
    end else if (!oe_i && wr_en_i) begin
      active_q <= wr_data_i;
    end else if (wrap_i) begin
      active_q <= pend_view;
    end
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (oe_i && !wrap_i) |=> $stable(active_q)); // R5
  AST_OE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!oe_i && wr_en_i) |=> (active_q == $past(wr_data_i))); // R6
  AST_WRAP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrap_i && wr_en_i) |=> (active_q == $past(wr_data_i))); // R8
endmodule

// File: rtl/pwm_output_stage.sv
module pwm_output_stage #(
  parameter int unsigned DUTY_W = pwm_mod250_pkg::DEF_DUTY_W,
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  localparam int unsigned CMP_W = pwm_mod250_pkg::max_u(DUTY_W, CNT_W);

  logic [CMP_W-1:0] cnt_x;
  logic [CMP_W-1:0] duty_x;
  logic             level;
  logic             pwm_q;

  assign cnt_x  = CMP_W'(cnt_i);
  assign duty_x = CMP_W'(duty_i);
  // High from count 0 until the count equals duty; codes past the period never match.
  assign level  = oe_i && (cnt_x < duty_x);
  assign pwm_o  = pwm_q;

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= level;
  end

  AST_OE_LOW: assert property (@(posedge clk) disable iff (rst)
    !oe_i |=> !pwm_q); // R9
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    (duty_i == '0) |=> !pwm_q); // R2
  AST_MATCH_LOW: assert property (@(posedge clk) disable iff (rst)
    (cnt_x == duty_x) |=> !pwm_q); // R4
endmodule

// File: rtl/pwm_mod250.sv
module pwm_mod250 #(
  parameter int unsigned DUTY_W = pwm_mod250_pkg::DEF_DUTY_W,
  parameter int unsigned PERIOD = pwm_mod250_pkg::DEF_PERIOD,
  parameter int unsigned RESET_DUTY = pwm_mod250_pkg::DEF_RESET_DUTY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              oe_i,
  input  logic              wr_en_i,
  input  logic [DUTY_W-1:0] wr_data_i,
  output logic [DUTY_W-1:0] rd_data_o,
  output logic              pwm_o
);
  localparam int unsigned CNT_W = $clog2(PERIOD);

  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [DUTY_W-1:0] active;

  pwm_period_counter #(.PERIOD(PERIOD)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .cnt_o(cnt), .wrap_o(wrap)
  );

  pwm_duty_buffer #(.DUTY_W(DUTY_W), .RESET_DUTY(RESET_DUTY)) u_buf (
    .clk(clk), .rst(rst), .oe_i(oe_i), .wrap_i(wrap),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .active_o(active)
  );

  pwm_output_stage #(.DUTY_W(DUTY_W), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .oe_i(oe_i), .cnt_i(cnt), .duty_i(active), .pwm_o(pwm_o)
  );

  assign rd_data_o = active;

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (oe_i && !tick_i) |=> $stable(rd_data_o)); // R7
endmodule

// File: tb/pwm_mod250_tb_top.sv
`timescale 1ns/1ps
module pwm_mod250_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       oe = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       pwm;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench model state
  int cnt_m = 0;
  int pend_m = 255;
  int act_m = 255;
  bit pwm_m = 1'b0;

  always #4 clk = ~clk;

  pwm_mod250 dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .oe_i(oe), .wr_en_i(we),
    .wr_data_i(wd), .rd_data_o(rd), .pwm_o(pwm)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive, clock once, update model, compare at next negedge.
  task automatic step(input bit tk, input bit en, input bit w, input int d, input string tag);
    bit wrap;
    tick = tk; oe = en; we = w; wd = 8'(d);
    @(posedge clk);
    pwm_m = en && (cnt_m < act_m);
    wrap = tk && (cnt_m == 249);
    if (!en && w) act_m = d;
    else if (wrap) act_m = w ? d : pend_m;
    if (w) pend_m = d;
    if (tk) cnt_m = (cnt_m == 249) ? 0 : cnt_m + 1;
    @(negedge clk);
    check({tag, " rd (R7)"}, int'(rd), act_m);
    check({tag, " pwm (R4)"}, int'(pwm), int'(pwm_m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int highs;
    int expd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset rd", int'(rd), 255);
    check("R1 reset pwm", int'(pwm), 0);

    // R10/R1: reset duty gives full-high period
    step(1, 1, 0, 0, "R10 prime");
    highs = 0;
    for (int i = 0; i < 250; i++) begin
      step(1, 1, 0, 0, "R10 reset duty");
      highs += int'(pwm);
    end
    check("R10 reset duty highs", highs, 250);

    // R2/R4/R6/R10: every duty code
    for (int d = 0; d < 256; d++) begin
      step(1, 0, 1, d, "R6 immediate");
      check("R6 immediate rd", int'(rd), d);
      step(1, 1, 0, 0, "R4 prime");
      highs = 0;
      for (int i = 0; i < 250; i++) begin
        step(1, 1, 0, 0, "R4 sweep");
        highs += int'(pwm);
      end
      expd = (d > 250) ? 250 : d;
      if (d == 0) check("R2 zero duty highs", highs, 0);
      else if (d >= 250) check("R10 saturated highs", highs, 250);
      else check("R4 duty highs", highs, expd);
    end

    // R5/R7: write mid-period while enabled stays pending
    step(1, 0, 1, 200, "R5 setup");
    while (cnt_m != 100) step(1, 1, 0, 0, "R5 advance");
    step(1, 1, 1, 40, "R5 write");
    check("R5 pending not read (R7)", int'(rd), 200);
    while (cnt_m != 249) step(1, 1, 0, 0, "R5 wait");
    check("R5 before wrap", int'(rd), 200);
    step(1, 1, 0, 0, "R5 wrap");
    check("R5 after wrap", int'(rd), 40);

    // R8: write in the wrap cycle
    while (cnt_m != 249) step(1, 1, 0, 0, "R8 advance");
    step(1, 1, 1, 77, "R8 wrap write");
    check("R8 wrap write rd", int'(rd), 77);

    // R3/R5: ticks held low freeze counter and block the transfer
    while (cnt_m != 249) step(1, 1, 0, 0, "R3 advance");
    step(0, 1, 1, 9, "R3 write no tick");
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0, "R3 no tick");
    check("R5 no tick no transfer", int'(rd), 77);
    step(1, 1, 0, 0, "R3 tick wrap");
    check("R3 wrap after stall", int'(rd), 9);

    // R9: disabled output stays low, counter keeps its phase
    highs = 0;
    for (int i = 0; i < 300; i++) begin
      step(1, 0, 0, 0, "R9 disabled");
      highs += int'(pwm);
    end
    check("R9 disabled highs", highs, 0);
    for (int i = 0; i < 260; i++) step(1, 1, 0, 0, "R9 re-enable");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule